// File: doc/BRIEF.md
# Issue Group Pipe Allocator

This block sits between instruction decode and the execution pipes of an in-order core. In every cycle it looks at up to three decoded operations, held in program order in slots 0 to 2. It decides which of them join the current issue group. For each operation that joins, it names the execution resource that operation gets.

There are three integer pipes, called R, S and T, and one floating-point result path. Any operation that cannot join the group is refused, and decode must offer it again in a later cycle. The decision is purely combinational from the slot inputs and one occupancy counter. Non-pipelined operations take every integer pipe for a fixed run of cycles, and the counter blocks all issue until that run has finished.

Operand values, dependency checks and the execution itself are handled elsewhere.

Top module: `ipa_alloc`

## Requirements
- R1: Reset clears all occupancy. The first group after reset is accepted in full: a branch (class 3), a simple op (class 0) and a simple op (class 0) get pipes R (1), S (2) and T (3).
- R2: Each slot carries a 4-bit class and gets a 3-bit pipe code. The pipe codes are NONE=0, R=1, S=2, T=3, ALL=4. Classes 0 (simple), 1 (load) and 2 (store) take S if S is still free in the group, otherwise T. A third such op in one group is refused.
- R3: A branch (class 3) is granted R only if no earlier slot in the group was granted R, S or T. Otherwise it is refused.
- R4: A load (class 1) and a store (class 2) never both join one group. Whichever of the two comes later in the group is refused.
- R5: A floating-point op (class 4) is granted T only when nothing else in the group has been granted yet. No later operation joins that group.
- R6: A non-pipelined op (classes 5 to 9) is granted ALL (4) only when nothing earlier in the group was granted. No later slot joins that group.
- R7: A non-pipelined op accepted in cycle c causes every request in cycles c+1 to c+L-1 to be refused. Requests are accepted again in cycle c+L. L is 5 for call (5), 2 for halfword multiply (6), 4 for word multiply (7), 10 for divide (8) and 10 for multi-register or vector ops (9).
- R8: Once a valid slot is refused, every later slot in that cycle is refused. A slot with valid low gets no accept and pipe NONE (0), and it does not stop later slots. Class codes 10 to 15 are always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | 3 | Per-slot operation present, slot 0 oldest |
| slot_cls | input | 12 | Per-slot 4-bit class, slot i in bits 4i+3:4i |
| slot_acc | output | 3 | Per-slot accept |
| slot_pipe | output | 9 | Per-slot 3-bit pipe grant, slot i in bits 3i+2:3i |

## Verification
The hardest condition to reach from the ports is the last refused cycle of a long hold, and the reopening cycle right after it. Reaching it requires a full, valid group to be offered on every cycle of the hold window.

To get there, the stimulus issues each non-pipelined class and then keeps presenting a complete branch/simple/simple group on every following cycle. The per-cycle reference model therefore sees the exact cycle in which acceptance resumes.

A long run of random classes, including the unused codes and valid bits that are low, then mixes holds with load/store and floating-point conflicts in arbitrary orders.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

  localparam logic [3:0] OP_SIMPLE = 4'd0;
  localparam logic [3:0] OP_LOAD   = 4'd1;
  localparam logic [3:0] OP_STORE  = 4'd2;
  localparam logic [3:0] OP_BRANCH = 4'd3;
  localparam logic [3:0] OP_FLOAT  = 4'd4;
  localparam logic [3:0] OP_CALL   = 4'd5;
  localparam logic [3:0] OP_MULH   = 4'd6;
  localparam logic [3:0] OP_MULW   = 4'd7;
  localparam logic [3:0] OP_DIV    = 4'd8;
  localparam logic [3:0] OP_MULTI  = 4'd9;

  localparam logic [2:0] PIPE_NONE = 3'd0;
  localparam logic [2:0] PIPE_R    = 3'd1;
  localparam logic [2:0] PIPE_S    = 3'd2;
  localparam logic [2:0] PIPE_T    = 3'd3;
  localparam logic [2:0] PIPE_ALL  = 3'd4;

  // Resources already taken by earlier slots of the current group
  typedef struct packed {
    logic r;
    logic s;
    logic t;
    logic fp;
    logic ld;
    logic st;
    logic stop;
  } grp_t;

endpackage

// File: rtl/ipa_slot.sv
module ipa_slot
  import ipa_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int LEN_CALL  = 5,
  parameter int LEN_MULH  = 2,
  parameter int LEN_MULW  = 4,
  parameter int LEN_DIV   = 10,
  parameter int LEN_MULTI = 10
) (
  input  grp_t             grp_i,
  input  logic             vld_i,
  input  logic [3:0]       cls_i,
  input  logic             busy_i,
  output logic             acc_o,
  output logic [2:0]       pipe_o,
  output grp_t             grp_o,
  output logic [CNT_W-1:0] hold_o
);

  logic empty;
  logic ok;
  logic [2:0] pick;
  logic [CNT_W-1:0] len_m1;

  assign empty = !(grp_i.r || grp_i.s || grp_i.t);

  always_comb begin
    ok     = 1'b0;
    pick   = PIPE_NONE;
    len_m1 = '0;
    case (cls_i)
      OP_SIMPLE, OP_LOAD, OP_STORE: begin
        ok   = !grp_i.t && !grp_i.fp &&
               !(cls_i == OP_LOAD && grp_i.st) &&
               !(cls_i == OP_STORE && grp_i.ld);
        pick = grp_i.s ? PIPE_T : PIPE_S;
      end
      OP_BRANCH: begin
        ok   = empty;
        pick = PIPE_R;
      end
      OP_FLOAT: begin
        ok   = empty;
        pick = PIPE_T;
      end
      OP_CALL:  begin ok = empty; pick = PIPE_ALL; len_m1 = CNT_W'(LEN_CALL - 1);  end
      OP_MULH:  begin ok = empty; pick = PIPE_ALL; len_m1 = CNT_W'(LEN_MULH - 1);  end
      OP_MULW:  begin ok = empty; pick = PIPE_ALL; len_m1 = CNT_W'(LEN_MULW - 1);  end
      OP_DIV:   begin ok = empty; pick = PIPE_ALL; len_m1 = CNT_W'(LEN_DIV - 1);   end
      OP_MULTI: begin ok = empty; pick = PIPE_ALL; len_m1 = CNT_W'(LEN_MULTI - 1); end
      default:  ok = 1'b0;
    endcase
  end

  always_comb begin
    acc_o  = vld_i && !grp_i.stop && !busy_i && ok;
    pipe_o = acc_o ? pick : PIPE_NONE;
    hold_o = acc_o ? len_m1 : '0;
    grp_o  = grp_i;
    if (vld_i && !acc_o) grp_o.stop = 1'b1;
    if (acc_o) begin
      case (pick)
        PIPE_R: grp_o.r = 1'b1;
        PIPE_S: grp_o.s = 1'b1;
        PIPE_T: grp_o.t = 1'b1;
        PIPE_ALL: begin
          grp_o.r    = 1'b1;
          grp_o.s    = 1'b1;
          grp_o.t    = 1'b1;
          grp_o.stop = 1'b1;
        end
        default: ;
      endcase
      if (cls_i == OP_FLOAT) grp_o.fp = 1'b1;
      if (cls_i == OP_LOAD)  grp_o.ld = 1'b1;
      if (cls_i == OP_STORE) grp_o.st = 1'b1;
    end
  end

endmodule

// File: rtl/ipa_hold.sv
module ipa_hold #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] load_i,
  output logic             busy_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (cnt_q != '0) || (load_i != '0);
    cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/ipa_alloc.sv
module ipa_alloc
  import ipa_pkg::*;
#(
  parameter int NSLOT     = 3,
  parameter int LEN_CALL  = 5,
  parameter int LEN_MULH  = 2,
  parameter int LEN_MULW  = 4,
  parameter int LEN_DIV   = 10,
  parameter int LEN_MULTI = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSLOT-1:0]     slot_vld,
  input  logic [4*NSLOT-1:0]   slot_cls,
  output logic [NSLOT-1:0]     slot_acc,
  output logic [3*NSLOT-1:0]   slot_pipe
);

  localparam int MAXLEN = (LEN_DIV > LEN_MULTI) ? LEN_DIV : LEN_MULTI;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  grp_t             grp [NSLOT+1];
  logic [CNT_W-1:0] hold [NSLOT];
  logic [CNT_W-1:0] load;
  logic             busy;

  assign grp[0] = '0;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    ipa_slot #(
      .CNT_W(CNT_W), .LEN_CALL(LEN_CALL), .LEN_MULH(LEN_MULH),
      .LEN_MULW(LEN_MULW), .LEN_DIV(LEN_DIV), .LEN_MULTI(LEN_MULTI)
    ) u_slot (
      .grp_i  (grp[i]),
      .vld_i  (slot_vld[i]),
      .cls_i  (slot_cls[4*i +: 4]),
      .busy_i (busy),
      .acc_o  (slot_acc[i]),
      .pipe_o (slot_pipe[3*i +: 3]),
      .grp_o  (grp[i+1]),
      .hold_o (hold[i])
    );
  end

  always_comb begin
    load = '0;
    for (int i = 0; i < NSLOT; i++) load = load | hold[i];
  end

  ipa_hold #(.CNT_W(CNT_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .busy_o (busy)
  );

endmodule

// File: rtl/ipa_alloc_chk.sv
module ipa_alloc_chk #(
  parameter int NSLOT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NSLOT-1:0]   slot_vld,
  input logic [4*NSLOT-1:0] slot_cls,
  input logic [NSLOT-1:0]   slot_acc,
  input logic [3*NSLOT-1:0] slot_pipe,
  input logic               busy
);

  logic [NSLOT-1:0] ld_a, st_a, fp_a, call_a, ref_before, st_before, s_before, br_a, t_int;

  always_comb begin
    logic rf, sg, ss;
    rf = 1'b0; sg = 1'b0; ss = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      ref_before[i] = rf;
      st_before[i]  = sg;
      s_before[i]   = ss;
      ld_a[i]   = slot_acc[i] && slot_cls[4*i +: 4] == 4'd1;
      st_a[i]   = slot_acc[i] && slot_cls[4*i +: 4] == 4'd2;
      fp_a[i]   = slot_acc[i] && slot_cls[4*i +: 4] == 4'd4;
      call_a[i] = slot_acc[i] && slot_cls[4*i +: 4] == 4'd5;
      br_a[i]   = slot_acc[i] && slot_pipe[3*i +: 3] == 3'd1;
      t_int[i]  = slot_acc[i] && slot_pipe[3*i +: 3] == 3'd3 && slot_cls[4*i +: 4] != 4'd4;
      if (slot_vld[i] && !slot_acc[i]) rf = 1'b1;
      if (slot_acc[i] && (slot_pipe[3*i +: 3] == 3'd2 || slot_pipe[3*i +: 3] == 3'd3)) sg = 1'b1;
      if (slot_acc[i] && slot_pipe[3*i +: 3] == 3'd2) ss = 1'b1;
    end
  end

  // R7
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> slot_acc == '0);

  // R7
  call_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_a != '0) |=> slot_acc == '0);

  // R4
  ld_st_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((ld_a != '0) && (st_a != '0)));

  // R5
  fp_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_a != '0) |-> $countones(slot_acc) == 1);

  for (genvar i = 0; i < NSLOT; i++) begin : g_chk
    // R8
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_acc[i] |-> !ref_before[i]);
    // R3
    branch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_a[i] |-> !st_before[i]);
    // R2
    s_before_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_int[i] |-> s_before[i]);
  end

endmodule

bind ipa_alloc ipa_alloc_chk #(.NSLOT(NSLOT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_vld  (slot_vld),
  .slot_cls  (slot_cls),
  .slot_acc  (slot_acc),
  .slot_pipe (slot_pipe),
  .busy      (busy)
);

// File: tb/ipa_alloc_tb.sv
module ipa_alloc_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  slot_vld = '0;
  logic [11:0] slot_cls = '0;
  logic [2:0]  slot_acc;
  logic [8:0]  slot_pipe;

  int n_chk = 0;
  int n_bad = 0;
  int mbusy = 0;

  always #5 clk = ~clk;

  ipa_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_cls(slot_cls),
    .slot_acc(slot_acc), .slot_pipe(slot_pipe)
  );

  function automatic int hold_len(input int c);
    case (c)
      5: return 5;
      6: return 2;
      7: return 4;
      8: return 10;
      default: return 10;
    endcase
  endfunction

  task automatic step(input string tag, input logic [2:0] v, input int c0, input int c1, input int c2);
    int cls [3];
    int used_st = 0, granted = 0, load = 0;
    bit r_used = 0, fp_used = 0, hl = 0, hs = 0, stopped = 0;
    cls[0] = c0; cls[1] = c1; cls[2] = c2;
    @(negedge clk);
    slot_vld = v;
    slot_cls = {4'(c2), 4'(c1), 4'(c0)};
    #1;
    for (int i = 0; i < 3; i++) begin
      bit ea = 0;
      int ep = 0;
      if (v[i]) begin
        if (!stopped && mbusy == 0) begin
          if (cls[i] <= 2) begin
            if (used_st < 2 && !fp_used && !(cls[i] == 1 && hs) && !(cls[i] == 2 && hl)) begin
              ea = 1; ep = (used_st == 0) ? 2 : 3; used_st++;
              if (cls[i] == 1) hl = 1;
              if (cls[i] == 2) hs = 1;
            end
          end else if (cls[i] == 3) begin
            if (!r_used && used_st == 0 && !fp_used) begin ea = 1; ep = 1; r_used = 1; end
          end else if (cls[i] == 4) begin
            if (granted == 0) begin ea = 1; ep = 3; fp_used = 1; end
          end else if (cls[i] <= 9) begin
            if (granted == 0) begin ea = 1; ep = 4; load = hold_len(cls[i]) - 1; stopped = 1; end
          end
        end
        if (!ea) stopped = 1;
        if (ea) granted++;
      end
      n_chk++;
      if (slot_acc[i] !== ea || int'(slot_pipe[3*i +: 3]) != ep) begin
        n_bad++;
        $display("FAIL %s slot %0d: acc/pipe got %b/%0d expected %b/%0d",
                 tag, i, slot_acc[i], slot_pipe[3*i +: 3], ea, ep);
      end
    end
    @(posedge clk);
    if (mbusy > 0) mbusy--; else mbusy = load;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: full group right after reset
    step("R1", 3'b111, 3, 0, 0);
    // R2: S then T, third refused
    step("R2", 3'b111, 0, 1, 0);
    step("R2", 3'b111, 2, 0, 2);
    // R3: branch behind an S/T op refused
    step("R3", 3'b111, 0, 3, 0);
    step("R3", 3'b111, 3, 3, 0);
    // R4: load/store conflict
    step("R4", 3'b111, 1, 2, 0);
    step("R4", 3'b011, 2, 1, 0);
    // R5: floating point alone
    step("R5", 3'b111, 4, 0, 3);
    step("R5", 3'b011, 0, 4, 0);
    // R6: non-pipelined only at group start
    step("R6", 3'b111, 0, 8, 0);
    step("R6", 3'b111, 3, 5, 0);
    // R7: each hold length, then full groups through the window
    for (int c = 5; c <= 9; c++) begin
      step("R7", 3'b001, c, 0, 0);
      for (int k = 0; k < 11; k++) step("R7", 3'b111, 3, 0, 0);
    end
    // R8: invalid slots and unused codes
    step("R8", 3'b110, 5, 3, 0);
    step("R8", 3'b101, 0, 3, 0);
    step("R8", 3'b111, 12, 0, 0);
    step("R8", 3'b111, 15, 3, 0);
    // R8: random mix
    for (int k = 0; k < 2000; k++)
      step("R8", 3'($urandom_range(0, 7)), $urandom_range(0, 11),
           $urandom_range(0, 11), $urandom_range(0, 11));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule